// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block carries out the commands that software writes into a hot-plug controller's command register. The controller looks after a parameterised number of slots. A command is an 8-bit code, a target slot number and a one-cycle strobe. The block runs each command in the cycle it is strobed, and the results are visible on the outputs in the next cycle.

For each slot the block holds three registered fields: the slot state, the power indicator and the attention indicator. Each slot also has a latch-open input, which shows that the slot's retention latch is open.

The block also holds:
- the secondary-bus speed setting;
- four command status flags: busy, latch-open, invalid-command and invalid-mode;
- a sticky command-detected bit.

Software clears the command-detected bit with an acknowledge pulse.

A command is either a single-slot command, a bus-speed setting, or one of two broadcast commands that act on every slot at once. Before a broadcast command changes anything, the block checks all slots. If any slot is already enabled, the command is refused as a whole. During a broadcast, a slot whose latch is open keeps its state and has its power indicator forced off.

Top module: `hpc_cmd_ctrl`

## Requirements
- R1: After reset, every slot's state is disabled (2'b11), its power and attention indicators are off (2'b11), the bus speed is 0, all four status flags are 0 and the command-detected bit is 0.
- R2: Each command strobe clears the busy, latch-open and invalid-mode flags, and clears the invalid-command flag unless that command is itself invalid. All of a command's results appear in the cycle after the strobe.
- R3: A code from 0x00 to 0x3F is a single-slot command. Bits [1:0] give the state (01 power-only, 10 enabled, 11 disabled), bits [3:2] give the power indicator and bits [5:4] give the attention indicator (01 on, 10 blink, 11 off). Each field is applied to the target slot; a field of 00 leaves it unchanged.
- R4: A single-slot command whose target is outside 1..NUM_SLOTS sets invalid-command and changes no slot.
- R5: A code from 0x40 to 0x47 loads the bus speed from code bits [2:0]. No other command changes the bus speed.
- R6: Code 0x48, when accepted, changes every slot as follows. A slot with its latch closed becomes power-only with its power indicator on. A slot with its latch open keeps its state and has its power indicator set off. Attention indicators are never changed.
- R7: Code 0x49, when accepted, acts like code 0x48, except that slots with a closed latch become enabled rather than power-only.
- R8: Code 0x48 or 0x49 issued while any slot is enabled sets invalid-command and changes no slot.
- R9: Any code from 0x4A to 0xFF sets invalid-command and changes neither the slots nor the bus speed.
- R10: Every command, valid or invalid, sets the command-detected bit. An acknowledge pulse clears the bit, and a command in the same cycle takes precedence over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | TGT_W | Target slot number, counted from 1 |
| latch_open | input | NUM_SLOTS | Retention latch open, one bit per slot |
| det_ack | input | 1 | Clears the command-detected bit |
| slot_state_o | output | 2*NUM_SLOTS | Slot state, slot i in bits [2i+1:2i] |
| pwr_ind_o | output | 2*NUM_SLOTS | Power indicator for each slot |
| attn_ind_o | output | 2*NUM_SLOTS | Attention indicator for each slot |
| bus_speed_o | output | 3 | Secondary-bus speed setting |
| stat_busy_o | output | 1 | Busy status flag |
| stat_latch_o | output | 1 | Latch-open status flag |
| stat_inv_cmd_o | output | 1 | Invalid-command status flag |
| stat_inv_mode_o | output | 1 | Invalid-mode status flag |
| cmd_det_o | output | 1 | Sticky command-detected bit |

## Verification
Every piece of state in this block is registered and drives an output port, so a wrong update shows up one cycle after the strobe that caused it. It appears either as a wrong 2-bit field for a slot, a changed bus speed, or an invalid-command flag in the wrong level. The most damaging fault is a refused broadcast that still changes a slot. That fault shows up at once on the state vector, and it is also visible in the next broadcast, which is accepted or refused on the basis of the wrong enabled slot. Latch-open slots are varied at random, so both branches of each broadcast are covered.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

   typedef enum logic [2:0] {
      K_SINGLE  = 3'd0,
      K_SPEED   = 3'd1,
      K_PWR_ALL = 3'd2,
      K_EN_ALL  = 3'd3,
      K_INVALID = 3'd4
   } cmd_kind_t;

   localparam logic [1:0] FLD_KEEP = 2'b00;
   localparam logic [1:0] ST_PWR   = 2'b01;
   localparam logic [1:0] ST_EN    = 2'b10;
   localparam logic [1:0] ST_DIS   = 2'b11;
   localparam logic [1:0] IND_ON   = 2'b01;
   localparam logic [1:0] IND_OFF  = 2'b11;

   typedef struct packed {
      logic [1:0] state;
      logic [1:0] pwr;
      logic [1:0] attn;
   } slot_upd_t;

   localparam logic [7:0] CODE_PWR_ALL = 8'h48;
   localparam logic [7:0] CODE_EN_ALL  = 8'h49;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
   import hpc_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int TGT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic [7:0]       code,
   input  logic [TGT_W-1:0] target,
   output cmd_kind_t        kind,
   output slot_upd_t        fields,
   output logic [2:0]       speed
);

   localparam int unsigned MAX_TGT = NUM_SLOTS;

   logic tgt_ok;

   assign tgt_ok = (target != '0) && (int'(target) <= MAX_TGT);

   always_comb begin
      fields.state = code[1:0];
      fields.pwr   = code[3:2];
      fields.attn  = code[5:4];
      speed        = code[2:0];
      if (code[7:6] == 2'b00)
         kind = tgt_ok ? K_SINGLE : K_INVALID;
      else if (code[7:3] == 5'b01000)
         kind = K_SPEED;
      else if (code == CODE_PWR_ALL)
         kind = K_PWR_ALL;
      else if (code == CODE_EN_ALL)
         kind = K_EN_ALL;
      else
         kind = K_INVALID;
   end

endmodule

// File: rtl/hpc_slot_reg.sv
module hpc_slot_reg
   import hpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd_en,
   input  slot_upd_t  upd,
   output logic [1:0] state_q,
   output logic [1:0] pwr_q,
   output logic [1:0] attn_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DIS;
         pwr_q   <= IND_OFF;
         attn_q  <= IND_OFF;
      end else if (upd_en) begin
         if (upd.state != FLD_KEEP) state_q <= upd.state;
         if (upd.pwr   != FLD_KEEP) pwr_q   <= upd.pwr;
         if (upd.attn  != FLD_KEEP) attn_q  <= upd.attn;
      end
   end

   AST_STATE_NEVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != FLD_KEEP); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(state_q) && $stable(pwr_q) && $stable(attn_q)); // R4

endmodule

// File: rtl/hpc_cmd_ctrl.sv
module hpc_cmd_ctrl
   import hpc_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int TGT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [7:0]             cmd_code,
   input  logic [TGT_W-1:0]       cmd_target,
   input  logic [NUM_SLOTS-1:0]   latch_open,
   input  logic                   det_ack,
   output logic [2*NUM_SLOTS-1:0] slot_state_o,
   output logic [2*NUM_SLOTS-1:0] pwr_ind_o,
   output logic [2*NUM_SLOTS-1:0] attn_ind_o,
   output logic [2:0]             bus_speed_o,
   output logic                   stat_busy_o,
   output logic                   stat_latch_o,
   output logic                   stat_inv_cmd_o,
   output logic                   stat_inv_mode_o,
   output logic                   cmd_det_o
);

   localparam int SW = 2 * NUM_SLOTS;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 31) begin : g_bad_slots
      $error("hpc_cmd_ctrl: NUM_SLOTS must be 1..31");
   end
   if ((1 << TGT_W) <= NUM_SLOTS) begin : g_bad_tgt
      $error("hpc_cmd_ctrl: TGT_W too narrow for NUM_SLOTS");
   end

   cmd_kind_t  kind;
   slot_upd_t  code_fields;
   logic [2:0] code_speed;

   hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .TGT_W(TGT_W)) u_dec (
      .code   (cmd_code),
      .target (cmd_target),
      .kind   (kind),
      .fields (code_fields),
      .speed  (code_speed)
   );

   logic [NUM_SLOTS-1:0] slot_en_vec;
   logic                 any_enabled;
   logic                 bcast;
   logic                 refused;
   logic                 invalid;

   assign any_enabled = |slot_en_vec;
   assign bcast       = (kind == K_PWR_ALL) || (kind == K_EN_ALL);
   assign refused     = bcast && any_enabled;
   assign invalid     = (kind == K_INVALID) || refused;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic       upd_en;
      slot_upd_t  upd;
      logic [1:0] st_q, pw_q, at_q;

      always_comb begin
         upd_en = 1'b0;
         upd    = '0;
         if (cmd_valid) begin
            if (kind == K_SINGLE && int'(cmd_target) == i + 1) begin
               upd_en = 1'b1;
               upd    = code_fields;
            end else if (bcast && !any_enabled) begin
               upd_en = 1'b1;
               if (latch_open[i]) begin
                  upd.state = FLD_KEEP;
                  upd.pwr   = IND_OFF;
               end else begin
                  upd.state = (kind == K_EN_ALL) ? ST_EN : ST_PWR;
                  upd.pwr   = IND_ON;
               end
               upd.attn = FLD_KEEP;
            end
         end
      end

      hpc_slot_reg u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .upd_en  (upd_en),
         .upd     (upd),
         .state_q (st_q),
         .pwr_q   (pw_q),
         .attn_q  (at_q)
      );

      assign slot_en_vec[i]        = (st_q == ST_EN);
      assign slot_state_o[2*i +: 2] = st_q;
      assign pwr_ind_o[2*i +: 2]    = pw_q;
      assign attn_ind_o[2*i +: 2]   = at_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_speed_o     <= '0;
         stat_busy_o     <= 1'b0;
         stat_latch_o    <= 1'b0;
         stat_inv_cmd_o  <= 1'b0;
         stat_inv_mode_o <= 1'b0;
         cmd_det_o       <= 1'b0;
      end else begin
         if (cmd_valid) begin
            stat_busy_o     <= 1'b0;
            stat_latch_o    <= 1'b0;
            stat_inv_mode_o <= 1'b0;
            stat_inv_cmd_o  <= invalid;
            if (kind == K_SPEED) bus_speed_o <= code_speed;
         end
         if (cmd_valid)    cmd_det_o <= 1'b1;
         else if (det_ack) cmd_det_o <= 1'b0;
      end
   end

   AST_CMD_SETS_DET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> cmd_det_o); // R10
   AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !stat_busy_o && !stat_latch_o && !stat_inv_mode_o); // R2
   AST_REFUSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && bcast && any_enabled |=> stat_inv_cmd_o && $stable(slot_state_o)
                                           && $stable(pwr_ind_o)); // R8
   AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code[7:3] != 5'b01000 |=> $stable(bus_speed_o)); // R5
   AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code >= 8'h4A |=> stat_inv_cmd_o && $stable(slot_state_o)
                                        && $stable(attn_ind_o)); // R9
   AST_ATTN_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && bcast |=> $stable(attn_ind_o)); // R6

endmodule

// File: tb/hpc_cmd_ctrl_test.sv
`timescale 1ns/1ps
module hpc_cmd_ctrl_test;
   localparam int N  = 4;
   localparam int TW = $clog2(N + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, det_ack = 1'b0;
   logic [7:0] cmd_code = '0;
   logic [TW-1:0] cmd_target = '0;
   logic [N-1:0] latch_open = '0;
   logic [2*N-1:0] st_o, pw_o, at_o;
   logic [2:0] spd_o;
   logic busy_o, lat_o, inv_o, mode_o, det_o;

   always #2.5 clk = ~clk;

   hpc_cmd_ctrl #(.NUM_SLOTS(N)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_target(cmd_target), .latch_open(latch_open), .det_ack(det_ack),
      .slot_state_o(st_o), .pwr_ind_o(pw_o), .attn_ind_o(at_o),
      .bus_speed_o(spd_o), .stat_busy_o(busy_o), .stat_latch_o(lat_o),
      .stat_inv_cmd_o(inv_o), .stat_inv_mode_o(mode_o), .cmd_det_o(det_o));

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [1:0] m_st [N], m_pw [N], m_at [N];
   logic [2:0] m_spd;
   logic m_inv, m_det;

   function automatic logic [2*N-1:0] pack(input logic [1:0] a [N]);
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) r[2*i +: 2] = a[i];
      return r;
   endfunction

   function automatic string tag_of(input logic [7:0] c, input int t);
      if (c < 8'h40) return (t >= 1 && t <= N) ? "R3" : "R4";
      if (c < 8'h48) return "R5";
      if (c == 8'h48) return "R6/R8";
      if (c == 8'h49) return "R7/R8";
      return "R9";
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(st_o === pack(m_st), tag, "slot state", st_o, pack(m_st));
      chk(pw_o === pack(m_pw), tag, "power ind", pw_o, pack(m_pw));
      chk(at_o === pack(m_at), tag, "attn ind", at_o, pack(m_at));
      chk(spd_o === m_spd, tag, "bus speed", spd_o, m_spd);
      chk(inv_o === m_inv, tag, "invalid cmd", inv_o, m_inv);
      chk({busy_o, lat_o, mode_o} === 3'b000, "R2", "other flags",
          {busy_o, lat_o, mode_o}, 3'b000);
      chk(det_o === m_det, "R10", "cmd detected", det_o, m_det);
   endtask

   task automatic model(input logic [7:0] c, input int t);
      bit any_en = 0;
      m_det = 1'b1;
      m_inv = 1'b0;
      if (c < 8'h40) begin
         if (t >= 1 && t <= N) begin
            if (c[1:0] != 2'b00) m_st[t-1] = c[1:0];
            if (c[3:2] != 2'b00) m_pw[t-1] = c[3:2];
            if (c[5:4] != 2'b00) m_at[t-1] = c[5:4];
         end else m_inv = 1'b1;
      end else if (c < 8'h48) begin
         m_spd = c[2:0];
      end else if (c == 8'h48 || c == 8'h49) begin
         for (int i = 0; i < N; i++) if (m_st[i] == 2'b10) any_en = 1;
         if (any_en) m_inv = 1'b1;
         else for (int i = 0; i < N; i++) begin
            if (latch_open[i]) m_pw[i] = 2'b11;
            else begin
               m_st[i] = (c == 8'h49) ? 2'b10 : 2'b01;
               m_pw[i] = 2'b01;
            end
         end
      end else m_inv = 1'b1;
   endtask

   task automatic send(input logic [7:0] c, input int t, input bit ack);
      cmd_valid = 1'b1; cmd_code = c; cmd_target = TW'(t); det_ack = ack;
      @(negedge clk);
      cmd_valid = 1'b0; det_ack = 1'b0;
      model(c, t);
      compare_all(tag_of(c, t));
   endtask

   task automatic ack_only();
      det_ack = 1'b1;
      @(negedge clk);
      det_ack = 1'b0;
      m_det = 1'b0;
      compare_all("R10");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < N; i++) begin m_st[i] = 2'b11; m_pw[i] = 2'b11; m_at[i] = 2'b11; end
      m_spd = '0; m_inv = 1'b0; m_det = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");
      // R3: full fields, then keep fields leave values alone
      send(8'h26, 1, 0);      // state en? no: 10 -> enabled, pwr 01, attn 10
      send(8'h00, 1, 0);
      send(8'h3F, 2, 0);
      // R8: slot 1 enabled -> both broadcasts refused
      send(8'h48, 0, 0);
      send(8'h49, 0, 0);
      // R2: valid command clears invalid flag
      send(8'h43, 0, 0);
      // R4: target 0 and beyond range
      send(8'h05, 0, 0);
      send(8'h05, N + 1, 0);
      send(8'h05, 7, 0);
      // R9 boundary codes
      send(8'h4A, 1, 0);
      send(8'hFF, 2, 0);
      // R10: ack clears; ack with command keeps set
      ack_only();
      send(8'h47, 0, 1);
      ack_only();
      // R6/R7 accepted with one latch open
      send(8'h03, 1, 0);
      latch_open = 4'b0100;
      send(8'h48, 0, 0);
      send(8'h49, 0, 0);
      latch_open = '0;
      for (int i = 1; i <= N; i++) send(8'h03, i, 0);
      latch_open = 4'b1001;
      send(8'h49, 0, 0);
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] c;
         int t, r;
         r = $urandom_range(0, 9);
         if (r < 5) c = 8'($urandom_range(0, 8'h3F));
         else if (r == 5) c = 8'($urandom_range(8'h40, 8'h47));
         else if (r == 6) c = 8'h48;
         else if (r == 7) c = 8'h49;
         else if (r == 8) c = 8'($urandom_range(8'h4A, 8'hFF));
         else c = 8'h03;
         t = (r == 9) ? $urandom_range(1, N) : $urandom_range(0, (1 << TW) - 1);
         latch_open = N'($urandom);
         if ($urandom_range(0, 7) == 0) ack_only();
         send(c, t, $urandom_range(0, 3) == 0);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule